// File: doc/BRIEF.md
# Bus Lockup Watchdog

This block watches the handshake of a pipelined bus master and catches a bus cycle that has stopped making progress. While the master holds its cycle line high, a down-counter is reloaded by every clock that carries a strobe or an acknowledge. If the counter runs out, the block drives a one-clock error into the error path that returns to the master. In the same clock it records the address the master is presenting.

Software reads the recorded address through a one-register slave port. The register always answers one clock after it is selected and never stalls. The timeout length is fixed at 0x2000 clocks and cannot be changed by software. The block shares the processor's reset, so a processor reset also restarts the watchdog and clears the recorded address.

Top module: `bus_hang_guard`

## Requirements
- R1: While reset is high, and in the first clock after it, `m_err_out` follows `m_err_in` only, and a read of the slave register returns 0.
- R2: With `m_cyc` high and neither `m_stb` nor `m_ack` high, a timeout fires on the 8192nd (0x2000) consecutive such clock after the last restart. This length is fixed.
- R3: Clocks with `m_cyc` low neither advance the count nor fire a timeout. Counting resumes from where it stopped when `m_cyc` returns high.
- R4: Any clock with `m_cyc` high and `m_stb` or `m_ack` high restarts the count from its full value.
- R5: `m_err_out` is the OR of `m_err_in` and the timeout. The timeout lasts exactly one clock.
- R6: After a timeout the count starts again from its full value, so a hang that continues raises a new timeout every 8192 idle clocks.
- R7: In the clock of a timeout, `m_adr` is captured. A read returns the captured address in bits [AW-1:0] and zeros above.
- R8: `s_ack` is high exactly one clock after a clock with `s_cyc` and `s_stb` both high. `s_stall` is always 0.
- R9: A write to the slave register (`s_we` high) is acknowledged like a read and leaves the captured address unchanged.
- R10: Reset clears the captured address to 0 and reloads the count, so a timeout needs a full 8192 idle clocks after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, shared with the processor reset |
| m_cyc | input | 1 | Master cycle line |
| m_stb | input | 1 | Master strobe |
| m_ack | input | 1 | Acknowledge returned to the master |
| m_err_in | input | 1 | Error from the bus fabric |
| m_adr | input | AW | Master address |
| m_err_out | output | 1 | Error delivered to the master |
| s_cyc | input | 1 | Slave port cycle |
| s_stb | input | 1 | Slave port strobe (register select) |
| s_we | input | 1 | Slave port write enable |
| s_ack | output | 1 | Slave port acknowledge |
| s_stall | output | 1 | Slave port stall, always 0 |
| s_rdata | output | 32 | Captured address, zero-extended |

## Verification
The assertions assume that reset is held from time zero until after the first clock edge. They also assume that `m_adr` settles before each edge, since the capture check compares the recorded value with the address of the previous clock. Beyond that, the master and slave inputs may take any pattern. The stimulus changes every input only at falling edges, holds reset for several clocks at the start, and reads the register with single-clock strobes. Every timeout interval is measured from a known restart edge, so the expected clock counts are exact.

// File: rtl/bus_hang_guard.sv
module bus_hang_guard #(
  parameter int AW     = 24,
  parameter int TW     = 15,
  parameter int RELOAD = 'h2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_cyc,
  input  logic          m_stb,
  input  logic          m_ack,
  input  logic          m_err_in,
  input  logic [AW-1:0] m_adr,
  output logic          m_err_out,
  input  logic          s_cyc,
  input  logic          s_stb,
  input  logic          s_we,
  output logic          s_ack,
  output logic          s_stall,
  output logic [31:0]   s_rdata
);

  localparam logic [TW-1:0] LOAD = TW'(RELOAD);

  logic [TW-1:0] cnt;
  logic          tmo;
  logic [AW-1:0] cap;
  logic          ack_q;

  wire kick   = m_cyc && (m_stb || m_ack);
  wire idle   = m_cyc && !kick;
  wire expire = idle && (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= LOAD;
      tmo   <= 1'b0;
      cap   <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= s_cyc && s_stb;
      tmo   <= expire;
      if (kick || expire)
        cnt <= LOAD;
      else if (idle)
        cnt <= cnt - TW'(1);
      if (expire)
        cap <= m_adr;
    end
  end

  assign m_err_out = m_err_in || tmo;
  assign s_ack     = ack_q;
  assign s_stall   = 1'b0;
  assign s_rdata   = 32'(cap);

  // R5
  tmo_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !tmo);

  // R5
  err_or_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo || m_err_in) |-> m_err_out);

  // R3
  frozen_when_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !m_cyc |=> ($stable(cnt) && !tmo));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == LOAD && !tmo));

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    tmo |-> (cap == $past(m_adr)));

  // R9
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_cyc && s_stb && s_we && !expire) |=> $stable(cap));

  // R8
  slave_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (s_cyc && s_stb) |=> s_ack);

  // R8
  slave_ack_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(s_cyc && s_stb) |=> !s_ack);

  // R8
  always_comb no_stall_chk: assert (s_stall == 1'b0);

endmodule

// File: tb/bus_hang_guard_tb.sv
module bus_hang_guard_tb_top;
  localparam time PERIOD = 10ns;
  localparam int  AW = 24;
  localparam int  TO = 8192;

  logic clk = 0, rst = 1;
  logic m_cyc = 0, m_stb = 0, m_ack = 0, m_err_in = 0;
  logic [AW-1:0] m_adr = '0;
  logic s_cyc = 0, s_stb = 0, s_we = 0;
  logic m_err_out, s_ack, s_stall;
  logic [31:0] s_rdata;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_hang_guard dut_i (
    .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_ack(m_ack),
    .m_err_in(m_err_in), .m_adr(m_adr), .m_err_out(m_err_out),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_ack(s_ack),
    .s_stall(s_stall), .s_rdata(s_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input string req, input logic [31:0] exp);
    @(negedge clk); s_cyc = 1; s_stb = 1; s_we = we;
    @(negedge clk); s_stb = 0; s_we = 0;
    chk(s_ack === 1'b1, {req, " ack"}, 32'(s_ack), 1);
    chk(s_stall === 1'b0, "R8 stall", 32'(s_stall), 0);
    chk(s_rdata === exp, {req, " data"}, s_rdata, exp);
    @(negedge clk); s_cyc = 0;
    chk(s_ack === 1'b0, "R8 ack single", 32'(s_ack), 0);
  endtask

  task automatic start_hang(input logic [AW-1:0] a);
    @(negedge clk); m_cyc = 1; m_stb = 1; m_adr = a;
    @(negedge clk); m_stb = 0;
  endtask

  // returns index of first negedge (from now) at which m_err_out is high, 0 if none
  task automatic wait_err(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim && n == 0; i++) begin
      @(negedge clk);
      if (m_err_out) n = i;
    end
  endtask

  task automatic t_reset;
    chk(m_err_out === 1'b0, "R1 err at reset", 32'(m_err_out), 0);
    repeat (3) @(negedge clk);
    rst = 0;
    chk(m_err_out === 1'b0, "R1 err after reset", 32'(m_err_out), 0);
    access(0, "R1 read", 0);
  endtask

  task automatic t_closed;
    int n;
    @(negedge clk); m_cyc = 0;
    wait_err(9000, n);
    chk(n == 0, "R3 no timeout while closed", n, 0);
  endtask

  task automatic t_basic;
    int n;
    start_hang(24'h12_3456);
    wait_err(TO + 10, n);
    chk(n == TO, "R2 timeout length", n, TO);
    @(negedge clk);
    chk(m_err_out === 1'b0, "R5 one-clock pulse", 32'(m_err_out), 0);
    wait_err(TO + 10, n);
    chk(n == TO - 1, "R6 refire", n, TO - 1);
    @(negedge clk); m_cyc = 0;
    access(0, "R7 capture", 32'h0012_3456);
  endtask

  task automatic t_kicks;
    int n;
    start_hang(24'h00_0001);
    repeat (8000) @(negedge clk);
    m_ack = 1; @(negedge clk); m_ack = 0;
    wait_err(8000, n);
    chk(n == 0, "R4 ack restarts", n, 0);
    m_stb = 1; @(negedge clk); m_stb = 0;
    wait_err(8100, n);
    chk(n == 0, "R4 stb restarts", n, 0);
    @(negedge clk); m_cyc = 0;
  endtask

  task automatic t_pause;
    int n;
    start_hang(24'hAB_CDEF);
    repeat (4000) @(negedge clk);
    m_cyc = 0;
    wait_err(5000, n);
    chk(n == 0, "R3 paused no timeout", n, 0);
    m_cyc = 1; m_adr = 24'h55_AA55;
    wait_err(TO, n);
    chk(n == TO - 4000, "R3 count resumes", n, TO - 4000);
    @(negedge clk); m_cyc = 0;
    access(0, "R7 address at expiry", 32'h0055_AA55);
  endtask

  task automatic t_errpass;
    @(negedge clk); m_err_in = 1;
    #1 chk(m_err_out === 1'b1, "R5 error passthrough", 32'(m_err_out), 1);
    @(negedge clk); m_err_in = 0;
    #1 chk(m_err_out === 1'b0, "R5 error clears", 32'(m_err_out), 0);
  endtask

  task automatic t_write;
    access(1, "R9 write ignored ack", 32'h0055_AA55);
    access(0, "R9 value kept", 32'h0055_AA55);
  endtask

  task automatic t_reset_mid;
    int n;
    start_hang(24'h77_0077);
    repeat (5000) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    wait_err(TO + 10, n);
    chk(n == TO, "R10 reset reloads count", n, TO);
    @(negedge clk); m_cyc = 0;
    rst = 1; @(negedge clk); rst = 0;
    access(0, "R10 reset clears capture", 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_closed();
    t_basic();
    t_kicks();
    t_pause();
    t_errpass();
    t_write();
    t_reset_mid();
    summary();
  end
endmodule